// File: doc/BRIEF.md
# I2C Interrupt Vector Encoder

This block sits beside the bus engine of an I2C controller and collects its seven event strobes into sticky status flags. Software programs a mask that selects which flags may interrupt. One interrupt request line is raised while any enabled flag is pending. A vector register reports one pending enabled event as a small code, so a handler can read that register repeatedly, service one event per read, and stop when it returns zero.

Reading the vector register changes state: the flag it reports is cleared. The two data-ready flags are the exception, because they follow a data condition and stay set until software clears them. Flags are also cleared by writing ones to the status register. Two level inputs, bus-busy and receive-shift-full, appear in the status word. They never produce a vector code and cannot be cleared by software.

Top module: `i2c_irq_vector`

## Requirements
- R1: After reset all seven event flags and the mask are zero, `irq` is low and `rdata` is zero. Reads of status, mask and vector all return 0.
- R2: A one on `ev_set[i]` sets status flag i at the next clock edge. The bit order is: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive data ready, 4 transmit data ready, 5 stop detected, 6 addressed as slave.
- R3: Writing the status register (`sel`=0) clears each flag whose `wdata` bit in [6:0] is 1. Flags whose `wdata` bit is 0 are left unchanged.
- R4: If an event strobe and a clear (by write or by vector read) hit the same flag in the same cycle, the flag ends up set.
- R5: The mask register (`sel`=1) stores `wdata[6:0]` on a write. It reads back with bits 15:7 equal to zero.
- R6: `irq` is high exactly when the bitwise AND of the flags and the mask is nonzero. It follows the registered state.
- R7: The vector register (`sel`=2) returns the bit index plus one of an enabled pending flag. This gives codes 1 to 7 for bits 0 to 6. It returns 0 when no enabled flag is pending, and masked flags are never reported.
- R8: When several enabled flags are pending, the vector returns the lowest code, so arbitration lost has the highest priority.
- R9: A vector read that returns a nonzero code clears the matching flag. Codes 4 (receive data ready) and 5 (transmit data ready) leave their flags set.
- R10: A status read shows `busy_in` at bit 12 and `rsfull_in` at bit 11, sampled in the read cycle. These bits produce no vector code, and writes to them have no effect.
- R11: `rdata` is registered. It holds the selected word in the cycle after `rd_en`, and it is zero after a cycle without `rd_en`. Select value 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_set | input | 7 | One-cycle event strobes from the bus engine |
| busy_in | input | 1 | Bus-busy level |
| rsfull_in | input | 1 | Receive-shift-full level |
| sel | input | 2 | Register select: 0 status, 1 mask, 2 vector, 3 unused |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume only that the inputs are stable at the clock edge and that the reset is held long enough to reach every register. They assume no exclusivity between the strobes. The stimulus is driven on the falling edge and deliberately mixes reads, writes and event strobes in the same cycle. This covers set-versus-clear races and vector reads during writes. A behavioural model tracks the flags and mask as integers and compares `rdata` and `irq` on every cycle. Directed sequences pin down the priority order and the data-ready exceptions.

// File: rtl/i2cv_pkg.sv
package i2cv_pkg;
  localparam int unsigned EVT_N  = 7;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_MASK = 2'd1,
    SEL_VEC  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/i2cv_flag_bank.sv
module i2cv_flag_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] flags_nxt;
  logic [N-1:0] flags_q;

  // set has priority over any clear source
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_comb begin
      flags_nxt[g] = flags_q[g];
      if (clr[g])    flags_nxt[g] = 1'b0;
      if (ev_set[g]) flags_nxt[g] = 1'b1;
    end

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_set[g] |=> flags[g]);
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[g] && !ev_set[g]) |=> !flags[g]);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr[g] && flags[g]) |=> flags[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_nxt;
  end

  assign flags = flags_q;
endmodule

// File: rtl/i2cv_vec_enc.sv
module i2cv_vec_enc #(
  parameter int unsigned N      = 7,
  parameter int unsigned CODE_W = 3
) (
  input  logic [N-1:0]      pending,
  output logic [CODE_W-1:0] code
);
  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    code = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pending[i]) code = CODE_W'(i + 1);
    end
  end

  always_comb begin
    p_code_range_r7: assert (code <= CODE_W'(N));
  end
endmodule

// File: rtl/i2cv_regif.sv
module i2cv_regif
  import i2cv_pkg::*;
#(
  parameter int unsigned N        = 7,
  parameter int unsigned W        = 16,
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned BUSY_POS = 12,
  parameter int unsigned RSF_POS  = 11,
  parameter logic [N-1:0] STICKY  = 7'b0011000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [W-1:0]      wdata,
  input  logic [N-1:0]      flags,
  input  logic [CODE_W-1:0] code,
  input  logic              busy_in,
  input  logic              rsfull_in,
  output logic [N-1:0]      mask,
  output logic [N-1:0]      w1c_clr,
  output logic [N-1:0]      vec_clr,
  output logic [W-1:0]      rdata
);
  localparam logic [N-1:0] ONE_N = N'(1);

  reg_sel_e      sel_e;
  logic          mask_en;
  logic [N-1:0]  mask_q;
  logic [W-1:0]  rd_word;
  logic [W-1:0]  rdata_nxt;
  logic [W-1:0]  rdata_q;

  assign sel_e   = reg_sel_e'(sel);
  assign mask_en = wr_en && (sel_e == SEL_MASK);

  always_comb begin
    w1c_clr = '0;
    if (wr_en && (sel_e == SEL_STAT)) w1c_clr = wdata[N-1:0];
  end

  always_comb begin
    vec_clr = '0;
    if (rd_en && (sel_e == SEL_VEC) && (code != '0))
      vec_clr = (ONE_N << (code - CODE_W'(1))) & ~STICKY;
  end

  always_comb begin
    rd_word = '0;
    unique case (sel_e)
      SEL_STAT: begin
        rd_word[N-1:0]  = flags;
        rd_word[BUSY_POS] = busy_in;
        rd_word[RSF_POS]  = rsfull_in;
      end
      SEL_MASK: rd_word[N-1:0]      = mask_q;
      SEL_VEC:  rd_word[CODE_W-1:0] = code;
      default:  rd_word = '0;
    endcase
    rdata_nxt = rd_en ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= wdata[N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_nxt;
  end

  assign mask  = mask_q;
  assign rdata = rdata_q;

  p_vec_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_clr));
  p_mask_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_en |=> $stable(mask));
  p_idle_rdata_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0));
endmodule

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector
  import i2cv_pkg::*;
#(
  parameter int unsigned N        = EVT_N,
  parameter int unsigned W        = WORD_W,
  parameter int unsigned BUSY_POS = 12,
  parameter int unsigned RSF_POS  = 11,
  parameter logic [N-1:0] STICKY  = 7'b0011000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_set,
  input  logic         busy_in,
  input  logic         rsfull_in,
  input  logic [1:0]   sel,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         irq
);
  localparam int unsigned CODE_W = $clog2(N + 1);

  logic [N-1:0]      flags;
  logic [N-1:0]      mask;
  logic [N-1:0]      enabled;
  logic [N-1:0]      w1c_clr;
  logic [N-1:0]      vec_clr;
  logic [N-1:0]      clr_all;
  logic [CODE_W-1:0] code;

  assign clr_all = w1c_clr | vec_clr;
  assign enabled = flags & mask;
  assign irq     = |enabled;

  i2cv_flag_bank #(.N(N)) i_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_set (ev_set),
    .clr    (clr_all),
    .flags  (flags)
  );

  i2cv_vec_enc #(.N(N), .CODE_W(CODE_W)) i_enc (
    .pending (enabled),
    .code    (code)
  );

  i2cv_regif #(
    .N(N), .W(W), .CODE_W(CODE_W),
    .BUSY_POS(BUSY_POS), .RSF_POS(RSF_POS), .STICKY(STICKY)
  ) i_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wdata     (wdata),
    .flags     (flags),
    .code      (code),
    .busy_in   (busy_in),
    .rsfull_in (rsfull_in),
    .mask      (mask),
    .w1c_clr   (w1c_clr),
    .vec_clr   (vec_clr),
    .rdata     (rdata)
  );

  p_irq_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (code != '0));
  p_code_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (code != '0) |-> enabled[code - CODE_W'(1)]);
endmodule

// File: tb/test_i2c_irq_vector.sv
module test_i2c_irq_vector;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  ev_set;
  logic        busy_in, rsfull_in;
  logic [1:0]  sel;
  logic        wr_en, rd_en;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_flags = 0;
  int m_mask  = 0;
  int m_rdata = 0;

  always #(CLK_P/2) clk = ~clk;

  i2c_irq_vector i_i2c_irq_vector (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .busy_in(busy_in),
    .rsfull_in(rsfull_in), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic int model_code();
    for (int i = 0; i < 7; i++)
      if (((m_flags & m_mask) >> i) & 1) return i + 1;
    return 0;
  endfunction

  // one clock: drive now (at negedge), update model at posedge, compare at next negedge
  task automatic cyc(input int s, input bit w, input bit r, input int wd, input int ev);
    int code, clr;
    sel = 2'(s); wr_en = w; rd_en = r; wdata = 16'(wd); ev_set = 7'(ev);
    @(posedge clk);
    code = model_code();
    m_rdata = 0;
    if (r) begin
      case (s)
        0: m_rdata = m_flags | (int'(busy_in) << 12) | (int'(rsfull_in) << 11);
        1: m_rdata = m_mask;
        2: m_rdata = code;
        default: m_rdata = 0;
      endcase
    end
    clr = (w && s == 0) ? (wd & 'h7f) : 0;
    if (r && s == 2 && code != 0 && code != 4 && code != 5) clr |= 1 << (code - 1);
    m_flags = (m_flags & ~clr) | (ev & 'h7f);
    if (w && s == 1) m_mask = wd & 'h7f;
    @(negedge clk);
    check(int'(rdata), m_rdata, "R11 rdata vs model");
    check(int'(irq), ((m_flags & m_mask) != 0) ? 1 : 0, "R6 irq vs model");
    wr_en = 0; rd_en = 0; ev_set = '0; wdata = '0; sel = '0;
  endtask

  task automatic rd(input int s, output int v);
    cyc(s, 0, 1, 0, 0);
    v = int'(rdata);
  endtask

  task automatic wr(input int s, input int wd);
    cyc(s, 1, 0, wd, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    rst_n = 0; ev_set = '0; busy_in = 0; rsfull_in = 0;
    sel = '0; wr_en = 0; rd_en = 0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(int'(irq), 0, "R1 irq after reset");
    check(int'(rdata), 0, "R1 rdata after reset");
    rd(0, v); check(v, 0, "R1 status after reset");
    rd(1, v); check(v, 0, "R1 mask after reset");
    rd(2, v); check(v, 0, "R1 vector after reset");

    // R2 event sets flag; R7 masked flag not reported
    cyc(0, 0, 0, 0, 'h04);
    rd(0, v); check(v, 'h0004, "R2 access-ready flag at bit 2");
    check(int'(irq), 0, "R6 irq low while masked");
    rd(2, v); check(v, 0, "R7 masked flag gives vector 0");

    // R5 mask width
    wr(1, 'hffff);
    rd(1, v); check(v, 'h007f, "R5 mask readback");
    check(int'(irq), 1, "R6 irq high once enabled");

    // R7/R9 vector read and auto-clear
    rd(2, v); check(v, 3, "R7 access-ready code");
    rd(0, v); check(v, 0, "R9 flag cleared by vector read");
    check(int'(irq), 0, "R6 irq drops");

    // R8 priority, R9 sticky data-ready
    cyc(0, 0, 0, 0, 'h4a);
    rd(2, v); check(v, 2, "R8 no-ack first");
    rd(2, v); check(v, 4, "R8 receive-ready next");
    rd(2, v); check(v, 4, "R9 receive-ready stays set");
    wr(0, 'h08);
    rd(2, v); check(v, 7, "R8 addressed-as-slave last");
    rd(2, v); check(v, 0, "R7 vector empty");
    cyc(0, 0, 0, 0, 'h10);
    rd(2, v); check(v, 5, "R9 transmit-ready code");
    rd(0, v); check(v, 'h10, "R9 transmit-ready stays set");

    // R3 write-one-to-clear
    cyc(0, 0, 0, 0, 'h21);
    wr(0, 'h00);
    rd(0, v); check(v, 'h31, "R3 zero write keeps flags");
    wr(0, 'h30);
    rd(0, v); check(v, 'h01, "R3 one write clears");

    // R4 set wins over clear
    cyc(0, 1, 0, 'h01, 'h01);
    rd(0, v); check(v, 'h01, "R4 set beats write clear");
    cyc(2, 0, 1, 0, 'h01);
    rd(0, v); check(v, 'h01, "R4 set beats vector clear");
    wr(0, 'h7f);

    // R10 level bits
    busy_in = 1; rsfull_in = 1;
    wr(0, 'h1800);
    rd(0, v); check(v, 'h1800, "R10 busy and shift-full bits");
    rd(2, v); check(v, 0, "R10 level bits give no code");
    busy_in = 0;
    rd(0, v); check(v, 'h0800, "R10 busy follows input");
    rsfull_in = 0;

    // R11 unused select
    cyc(0, 0, 0, 0, 'h7f);
    rd(3, v); check(v, 0, "R11 select 3 reads zero");
    wr(0, 'h7f);

    // mixed traffic against the model
    for (int k = 0; k < 600; k++) begin
      busy_in   = 1'($urandom_range(0, 1));
      rsfull_in = 1'($urandom_range(0, 1));
      cyc(int'($urandom_range(0, 3)), 1'($urandom_range(0, 3) == 0),
          1'($urandom_range(0, 1)), int'($urandom_range(0, 'hffff)),
          ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 'h7f)) : 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule